// File: doc/BRIEF.md
# Single-Cycle 32-Bit RISC Core

This block is a small 32-bit processor core that completes one instruction on every rising clock edge. It supports word loads and stores, five register-to-register operations (add, subtract, AND, OR, signed set-less-than), branch-if-equal and an absolute jump. Inside it are the program counter, a 32 x 32-bit register file with two combinational read ports and one write port, a sign extender, an ALU with a zero flag, and a two-level decoder. The decoder first derives a 2-bit operation class from the opcode and then resolves the exact ALU function from the funct field. The core also contains the next-PC selection logic and two separate word-addressed memories, one for instructions and one for data.

A testbench or system loader fills both memories through a load port while reset is held. Once reset is released, the core fetches from address 0. Every store appears on a set of store-observation outputs, and any data word can be read back through a combinational peek port. Instructions have three formats. Every format places the opcode in bits 31:26. Register operations use rs 25:21, rt 20:16 and rd 15:11, with funct in 5:0. Loads, stores and branches carry a 16-bit immediate in bits 15:0. A jump carries a 26-bit word target in bits 25:0.

The core has no control state machine. Its only state is the program counter, the register file and the data memory, so it has no named states and no named transitions.

Top module: `sc_core`

## Requirements
- R1: While `rst` is 1 at a rising edge, the program counter becomes 0 and no register or data-memory write from the core takes place.
- R2: Any instruction that is not a jump and is not a taken branch advances the PC by 4. An opcode outside {0, 2, 4, 35, 43} is a no-op: it writes no register and no memory.
- R3: For opcode 0, funct 0x20 writes rs+rt to rd and funct 0x22 writes rs-rt to rd.
- R4: For opcode 0, funct 0x24 writes rs AND rt to rd and funct 0x25 writes rs OR rt to rd.
- R5: For opcode 0, funct 0x2A writes 1 to rd when rs is less than rt as signed 32-bit values, and 0 otherwise.
- R6: Opcode 35 (load word) writes the data word at byte address rs + sign-extended imm[15:0] to rt.
- R7: Opcode 43 (store word) writes rt to the data word at byte address rs + sign-extended imm[15:0]. During that cycle, `mem_we_o` is 1 and `mem_addr_o` and `mem_wdata_o` show the address and the data. No other opcode raises `mem_we_o`.
- R8: Opcode 4 (branch-if-equal) sets the next PC to PC+4+(sign-extended imm << 2) when rs equals rt, and to PC+4 otherwise.
- R9: Opcode 2 (jump) sets the next PC to {PC+4 bits 31:28, instr[25:0], 2'b00}.
- R10: Register 0 always reads as zero and ignores writes. A write to any other register is visible on the next cycle.
- R11: When `load_en` is 1 at a rising edge, `load_data` is written to word `load_addr` of the instruction memory if `load_to_imem` is 1, or of the data memory otherwise. `peek_data` shows data word `peek_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Memory preload strobe |
| load_to_imem | input | 1 | 1 selects instruction memory, 0 data memory |
| load_addr | input | LAW | Word index for preload |
| load_data | input | 32 | Preload word |
| peek_addr | input | DAW | Data memory word index to observe |
| peek_data | output | 32 | Data word at `peek_addr` |
| pc_o | output | 32 | Current program counter |
| mem_we_o | output | 1 | Store in progress this cycle |
| mem_addr_o | output | 32 | Byte address computed by the ALU |
| mem_wdata_o | output | 32 | Store data (rt) |

## Verification
The embedded assertions cover properties that hold on every cycle. They check that the PC steps by 4 unless control flow is redirected, and that a taken branch only occurs when the two register operands are equal. They also check that a jump lands on the encoded word target, that only a store opcode raises the store strobe, that reset clears the PC, and that a register write to a nonzero index lands. The directed scenarios are the only way to show the actual arithmetic and logic results, the signed comparison, negative load/store offsets, the branch target arithmetic in both directions of the decision, the no-op behaviour of unknown opcodes, and that register 0 stays zero after being targeted.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

    localparam logic [5:0] OPC_REG   = 6'd0;
    localparam logic [5:0] OPC_JUMP  = 6'd2;
    localparam logic [5:0] OPC_BEQ   = 6'd4;
    localparam logic [5:0] OPC_LOAD  = 6'd35;
    localparam logic [5:0] OPC_STORE = 6'd43;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [1:0] {
        CLS_ADDR  = 2'b00,
        CLS_CMP   = 2'b01,
        CLS_FUNCT = 2'b10
    } op_class_e;

    typedef enum logic [3:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111,
        ALU_NOR = 4'b1100
    } alu_fn_e;

    typedef struct packed {
        logic      reg_we;
        logic      dst_is_rd;
        logic      b_is_imm;
        logic      mem_we;
        logic      wb_from_mem;
        logic      is_branch;
        logic      is_jump;
        op_class_e op_class;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_core_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl,
    output alu_fn_e    alu_fn
);

    // first level: opcode -> control word and operation class
    always_comb begin
        ctrl = '0;
        ctrl.op_class = CLS_ADDR;
        unique case (opcode)
            OPC_REG: begin
                ctrl.reg_we    = 1'b1;
                ctrl.dst_is_rd = 1'b1;
                ctrl.op_class  = CLS_FUNCT;
            end
            OPC_LOAD: begin
                ctrl.reg_we      = 1'b1;
                ctrl.b_is_imm    = 1'b1;
                ctrl.wb_from_mem = 1'b1;
            end
            OPC_STORE: begin
                ctrl.b_is_imm = 1'b1;
                ctrl.mem_we   = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.is_branch = 1'b1;
                ctrl.op_class  = CLS_CMP;
            end
            OPC_JUMP: ctrl.is_jump = 1'b1;
            default: ctrl = '0;
        endcase
    end

    // second level: class refined by funct
    always_comb begin
        alu_fn = ALU_ADD;
        unique case (ctrl.op_class)
            CLS_ADDR: alu_fn = ALU_ADD;
            CLS_CMP:  alu_fn = ALU_SUB;
            CLS_FUNCT: begin
                unique case (funct)
                    FN_ADD:  alu_fn = ALU_ADD;
                    FN_SUB:  alu_fn = ALU_SUB;
                    FN_AND:  alu_fn = ALU_AND;
                    FN_OR:   alu_fn = ALU_OR;
                    FN_SLT:  alu_fn = ALU_SLT;
                    default: alu_fn = ALU_ADD;
                endcase
            end
            default: alu_fn = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int RAW = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [RAW-1:0] wa,
    input  logic [W-1:0]   wd,
    input  logic [RAW-1:0] ra1,
    input  logic [RAW-1:0] ra2,
    output logic [W-1:0]   rd1,
    output logic [W-1:0]   rd2
);

    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (we && wa != '0) regs[wa] <= wd;
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

    // R10: a write to a nonzero index is readable on the following cycle
    a_r10_write_lands: assert property (@(posedge clk) disable iff (rst)
        (we && wa != '0) |=> regs[$past(wa)] == $past(wd));

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_fn_e      fn,
    output logic [W-1:0] y,
    output logic         zero
);

    always_comb begin
        unique case (fn)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, $signed(a) < $signed(b)};
            ALU_NOR: y = ~(a | b);
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_core_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS),
    localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load_en,
    input  logic           load_to_imem,
    input  logic [LAW-1:0] load_addr,
    input  logic [31:0]    load_data,
    input  logic [DAW-1:0] peek_addr,
    output logic [31:0]    peek_data,
    output logic [31:0]    pc_o,
    output logic           mem_we_o,
    output logic [31:0]    mem_addr_o,
    output logic [31:0]    mem_wdata_o
);

    logic [31:0] imem [IMEM_WORDS];
    logic [31:0] dmem [DMEM_WORDS];

    logic [31:0] pc, pc_next, pc_plus4, br_target, jmp_target;
    logic [31:0] instr, imm_ext, rs_val, rt_val, alu_b, alu_y, wb_data, mem_rdata;
    logic [5:0]  opcode;
    logic [4:0]  rs_idx, rt_idx, rd_idx, wr_idx;
    logic        alu_zero, take_branch;
    ctrl_t       ctrl;
    alu_fn_e     alu_fn;

    // fetch and field split
    assign instr  = imem[pc[IAW+1:2]];
    assign opcode = instr[31:26];
    assign rs_idx = instr[25:21];
    assign rt_idx = instr[20:16];
    assign rd_idx = instr[15:11];

    // sign extender
    assign imm_ext = {{16{instr[15]}}, instr[15:0]};

    sc_decode u_decode (
        .opcode (opcode),
        .funct  (instr[5:0]),
        .ctrl   (ctrl),
        .alu_fn (alu_fn)
    );

    assign wr_idx = ctrl.dst_is_rd ? rd_idx : rt_idx;

    sc_regfile #(.NREG(32), .W(32)) u_regs (
        .clk (clk),
        .rst (rst),
        .we  (ctrl.reg_we & ~rst),
        .wa  (wr_idx),
        .wd  (wb_data),
        .ra1 (rs_idx),
        .ra2 (rt_idx),
        .rd1 (rs_val),
        .rd2 (rt_val)
    );

    assign alu_b = ctrl.b_is_imm ? imm_ext : rt_val;

    sc_alu #(.W(32)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .fn   (alu_fn),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign mem_rdata = dmem[alu_y[DAW+1:2]];
    assign wb_data   = ctrl.wb_from_mem ? mem_rdata : alu_y;

    // next-PC selection
    assign pc_plus4    = pc + 32'd4;
    assign br_target   = pc_plus4 + {imm_ext[29:0], 2'b00};
    assign jmp_target  = {pc_plus4[31:28], instr[25:0], 2'b00};
    assign take_branch = ctrl.is_branch & alu_zero;

    always_comb begin
        if (ctrl.is_jump)     pc_next = jmp_target;
        else if (take_branch) pc_next = br_target;
        else                  pc_next = pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (rst) pc <= '0;
        else     pc <= pc_next;
    end

    // memories: preload port has priority over core stores
    always_ff @(posedge clk) begin
        if (load_en && load_to_imem) imem[load_addr[IAW-1:0]] <= load_data;
    end

    always_ff @(posedge clk) begin
        if (load_en && !load_to_imem) dmem[load_addr[DAW-1:0]] <= load_data;
        else if (mem_we_o)            dmem[alu_y[DAW+1:2]]     <= rt_val;
    end

    assign peek_data   = dmem[peek_addr];
    assign pc_o        = pc;
    assign mem_we_o    = ctrl.mem_we & ~rst;
    assign mem_addr_o  = alu_y;
    assign mem_wdata_o = rt_val;

    // R1: reset forces the PC to zero
    a_r1_reset_pc: assert property (@(posedge clk) rst |=> pc == '0);

    // R2: sequential flow steps by one word
    a_r2_step_four: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.is_jump && !take_branch) |=> pc == $past(pc) + 32'd4);

    // R7: only the store opcode raises the store strobe
    a_r7_store_only: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> opcode == OPC_STORE);

    // R8: a taken branch means the register operands matched
    a_r8_taken_equal: assert property (@(posedge clk) disable iff (rst)
        take_branch |-> rs_val == rt_val);

    // R9: a jump lands on the encoded word target
    a_r9_jump_field: assert property (@(posedge clk) disable iff (rst)
        ctrl.is_jump |=> pc[27:0] == {$past(instr[25:0]), 2'b00});

    // R2: at most one kind of side effect per instruction
    a_r2_one_effect: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctrl.reg_we, ctrl.mem_we, ctrl.is_branch, ctrl.is_jump}));

endmodule

// File: tb/sc_core_bench.sv
`timescale 1ns/1ps
module sc_core_bench;

    localparam int IW  = 64;
    localparam int DW  = 64;
    localparam int IAW = $clog2(IW);
    localparam int DAW = $clog2(DW);
    localparam int LAW = (IAW > DAW) ? IAW : DAW;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           load_en = 1'b0;
    logic           load_to_imem = 1'b0;
    logic [LAW-1:0] load_addr = '0;
    logic [31:0]    load_data = '0;
    logic [DAW-1:0] peek_addr = '0;
    logic [31:0]    peek_data, pc_o, mem_addr_o, mem_wdata_o;
    logic           mem_we_o;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] prog [IW];
    logic [31:0] data [DW];

    always #5 clk = ~clk;

    sc_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) u_sc_core (
        .clk (clk), .rst (rst), .load_en (load_en), .load_to_imem (load_to_imem),
        .load_addr (load_addr), .load_data (load_data), .peek_addr (peek_addr),
        .peek_data (peek_data), .pc_o (pc_o), .mem_we_o (mem_we_o),
        .mem_addr_o (mem_addr_o), .mem_wdata_o (mem_wdata_o)
    );

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                          input logic [5:0] fn);
        return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                          input logic [15:0] imm);
        return {op, rs[4:0], rt[4:0], imm};
    endfunction

    function automatic logic [31:0] enc_j(input logic [25:0] tgt);
        return {6'd2, tgt};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic peek(input int idx, output logic [31:0] v);
        peek_addr = idx[DAW-1:0];
        #1 v = peek_data;
    endtask

    task automatic clear_images();
        for (int i = 0; i < IW; i++) prog[i] = 32'h0;
        for (int i = 0; i < DW; i++) data[i] = 32'h0;
    endtask

    // holds reset, pushes both images through the load port
    task automatic install();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < IW; i++) begin
            load_en = 1'b1; load_to_imem = 1'b1;
            load_addr = i[LAW-1:0]; load_data = prog[i];
            @(negedge clk);
        end
        for (int i = 0; i < DW; i++) begin
            load_en = 1'b1; load_to_imem = 1'b0;
            load_addr = i[LAW-1:0]; load_data = data[i];
            @(negedge clk);
        end
        load_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic run(input int n);
        rst = 1'b0;
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 pc after reset", pc_o, 32'h0);
        check("R1 no store in reset", {31'b0, mem_we_o}, 32'h0);
    endtask

    task automatic t_arith();
        logic [31:0] v;
        clear_images();
        data[0] = 32'd7; data[1] = 32'hFFFF_FFFD;
        prog[0]  = enc_i(6'd35, 0, 1, 16'd0);
        prog[1]  = enc_i(6'd35, 0, 2, 16'd4);
        prog[2]  = enc_r(1, 2, 3, 6'h20);
        prog[3]  = enc_r(1, 2, 4, 6'h22);
        prog[4]  = enc_r(1, 2, 5, 6'h24);
        prog[5]  = enc_r(1, 2, 6, 6'h25);
        prog[6]  = enc_r(2, 1, 7, 6'h2A);
        prog[7]  = enc_r(1, 2, 8, 6'h2A);
        prog[8]  = enc_i(6'd43, 0, 3, 16'd16);
        prog[9]  = enc_i(6'd43, 0, 4, 16'd20);
        prog[10] = enc_i(6'd43, 0, 5, 16'd24);
        prog[11] = enc_i(6'd43, 0, 6, 16'd28);
        prog[12] = enc_i(6'd43, 0, 7, 16'd32);
        prog[13] = enc_i(6'd43, 0, 8, 16'd36);
        install();
        run(14);
        check("R2 pc after 14 straight-line", pc_o, 32'd56);
        peek(4, v); check("R3 add", v, 32'd4);
        peek(5, v); check("R3 sub", v, 32'd10);
        peek(6, v); check("R4 and", v, 32'd5);
        peek(7, v); check("R4 or", v, 32'hFFFF_FFFF);
        peek(8, v); check("R5 slt negative<positive", v, 32'd1);
        peek(9, v); check("R5 slt positive<negative", v, 32'd0);
    endtask

    task automatic t_ldst_offset();
        logic [31:0] v;
        clear_images();
        data[2] = 32'd32; data[7] = 32'h0000_ABCD;
        prog[0] = enc_i(6'd35, 0, 1, 16'd8);
        prog[1] = enc_i(6'd35, 1, 2, 16'hFFFC);
        prog[2] = enc_i(6'd43, 1, 2, 16'hFFF8);
        install();
        run(2);
        check("R7 store strobe", {31'b0, mem_we_o}, 32'd1);
        check("R7 store address", mem_addr_o, 32'd24);
        check("R6 loaded with negative offset", mem_wdata_o, 32'h0000_ABCD);
        run(1);
        peek(6, v); check("R7 stored word", v, 32'h0000_ABCD);
    endtask

    task automatic t_branch();
        clear_images();
        data[0] = 32'd7; data[1] = 32'd9;
        prog[0] = enc_i(6'd35, 0, 1, 16'd0);
        prog[1] = enc_i(6'd35, 0, 2, 16'd0);
        prog[2] = enc_i(6'd35, 0, 3, 16'd4);
        prog[3] = enc_i(6'd4, 1, 2, 16'd2);
        prog[6] = enc_i(6'd4, 1, 3, 16'd5);
        install();
        run(4);
        check("R8 taken branch target", pc_o, 32'd24);
        run(1);
        check("R8 not-taken falls through", pc_o, 32'd28);
    endtask

    task automatic t_jump();
        clear_images();
        prog[0]  = enc_j(26'h10);
        prog[16] = enc_j(26'h3);
        install();
        run(1);
        check("R9 jump forward", pc_o, 32'h40);
        run(1);
        check("R9 jump back", pc_o, 32'hC);
    endtask

    task automatic t_noop();
        logic [31:0] v;
        clear_images();
        data[0] = 32'd7;
        prog[0] = enc_i(6'd35, 0, 5, 16'd0);
        prog[1] = enc_i(6'h3F, 5, 5, 16'd0);
        prog[2] = enc_i(6'd43, 0, 5, 16'd40);
        install();
        run(1);
        check("R2 unknown opcode no store", {31'b0, mem_we_o}, 32'd0);
        run(1);
        check("R2 unknown opcode advances pc", pc_o, 32'd8);
        run(1);
        peek(10, v); check("R2 unknown opcode left register intact", v, 32'd7);
    endtask

    task automatic t_zero_reg();
        logic [31:0] v;
        clear_images();
        data[0] = 32'd7; data[11] = 32'h55;
        prog[0] = enc_i(6'd35, 0, 0, 16'd0);
        prog[1] = enc_r(1, 1, 0, 6'h25);
        prog[2] = enc_i(6'd43, 0, 0, 16'd44);
        install();
        run(3);
        peek(11, v); check("R10 register 0 stays zero", v, 32'd0);
    endtask

    task automatic t_peek_load();
        logic [31:0] v;
        clear_images();
        data[63] = 32'hCAFE_F00D;
        install();
        peek(63, v); check("R11 preload and peek", v, 32'hCAFE_F00D);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_peek_load();
        t_arith();
        t_ldst_offset();
        t_branch();
        t_jump();
        t_noop();
        t_zero_reg();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule